// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache that sits between a 32-bit processor and a word-wide memory. Each line holds eight 32-bit words, so a line covers 32 bytes. The processor side accepts word loads and stores, with byte enables on stores, through a valid/ready request port. Results come back on a one-cycle response strobe. Stores follow a write-back, write-allocate policy. A miss first writes back a dirty victim, then refills the line one word per cycle, and then serves the request from the freshly filled line.

The same request port also carries six line-maintenance operations: clean, flush and invalidate. Each comes in two forms. The address form acts only when the tag matches. The index form picks the line by a bare set number and does no tag comparison. Any write-back a maintenance operation needs uses the same memory sequence as a victim eviction. After reset the block clears all of its line state, one line per cycle, before it accepts any request.

Top module: `dcache_wb`

## Requirements
- R1: `req_op` encodes 0 load, 1 store, 2 clean-by-address, 3 flush-by-address, 4 invalidate-by-address, 5 clean-by-index, 6 flush-by-index, 7 invalidate-by-index. Index-form operations take the set number from `req_addr[IDX_W-1:0]`.
- R2: Capacity `CACHE_BYTES` is one of 1024 to 16384 bytes. The byte offset is `addr[4:0]`, the set index is the next log2(CACHE_BYTES/32) bits, and the rest is the tag. After reset `req_ready` stays low for exactly CACHE_BYTES/32 cycles while every line is made invalid and clean.
- R3: A load hit returns the addressed word with `rsp_valid` high for one cycle, at the second rising edge after the request is accepted, and causes no memory traffic.
- R4: A store hit updates only the bytes whose `req_be` bit is set (bit n covers data bits 8n+7:8n), marks the line dirty, and causes no memory traffic.
- R5: A miss refills the line with eight reads of ascending word addresses from the line base, one per accepted memory cycle. The processor port stays stalled until all eight words are stored, and then the requested word is returned.
- R6: On a miss whose victim is valid and dirty, eight writes of the victim, lowest word first, go to the address rebuilt from the stored tag and the index. All of them come before any refill read.
- R7: A store miss allocates the line by refill and then merges the store data into it.
- R8: Clean-by-address on a hit writes the line back if it is dirty, then leaves it valid and clean.
- R9: Flush-by-address on a hit writes the line back if it is dirty, then invalidates it.
- R10: Invalidate-by-address on a hit invalidates the line and never writes it back, even if it is dirty.
- R11: An address-form maintenance operation that misses changes no line state, makes no memory access and responds at the second edge after acceptance.
- R12: The index-form clean, flush and invalidate follow the same write-back and valid/dirty rules as R8 to R10, with no tag comparison. On an invalid line they make no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_op | input | 3 | Operation code (R1) |
| req_addr | input | 32 | Byte address, or set index for index-form operations |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Load data; zero for other operations |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rvalid | input | 1 | Read data returned, in order |
| mem_rdata | input | 32 | Read data |

## Verification
On every cycle the assertions check four things. Memory writes happen only for a line that is valid and dirty, and never for an invalidate. A finished refill leaves the line valid, clean and tagged with the request's tag. Store hits, address-form misses and completed clean or flush operations leave the valid and dirty bits in the required state. Only the bench's scenarios can show that data written back reaches memory, and that a clean or flush really persists the data while an invalidate discards it. This is seen by evicting or refetching the line and comparing the returned words. The scenarios also cover the exact number and order of memory accesses, the hit latency and the length of the reset sweep.

// File: rtl/dcache_wb.sv
module dcache_wb #(
  parameter int CACHE_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_be,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int OFF_W = 5;
  localparam int LINE_WORDS = 8;
  localparam int LINES = CACHE_BYTES / 32;
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = 32 - OFF_W - IDX_W;

  localparam logic [2:0] OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_CLN_A = 3'd2, OP_FLS_A = 3'd3,
                         OP_INV_A = 3'd4, OP_CLN_I = 3'd5, OP_FLS_I = 3'd6, OP_INV_I = 3'd7;

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_LOOK, S_WB, S_FILL, S_MFIN} st_t;

  st_t               state_q;
  logic [2:0]        op_q;
  logic [31:0]       addr_q, wdata_q;
  logic [3:0]        be_q;
  logic [IDX_W-1:0]  sweep_q;
  logic [3:0]        wcnt_q;
  logic [2:0]        rcnt_q;

  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [31:0]       data_q [LINES*LINE_WORDS];

  wire              by_idx   = op_q >= OP_CLN_I;
  wire              is_mem   = (op_q == OP_LOAD) || (op_q == OP_STORE);
  wire [IDX_W-1:0]  idx      = by_idx ? addr_q[IDX_W-1:0] : addr_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tagf     = addr_q[31 -: TAG_W];
  wire [2:0]        woff     = addr_q[4:2];
  wire              hit      = valid_q[idx] && (tag_q[idx] == tagf);
  wire              sel      = by_idx || hit;
  wire              vdirty   = valid_q[idx] && dirty_q[idx];
  wire              k_clean  = (op_q == OP_CLN_A) || (op_q == OP_CLN_I);
  wire              k_inval  = (op_q == OP_INV_A) || (op_q == OP_INV_I);
  wire [31:0]       cur_word = data_q[{idx, woff}];
  wire              need_wb  = vdirty && !k_inval;

  logic [31:0] merged;
  always_comb begin
    for (int b = 0; b < 4; b++)
      merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : cur_word[8*b +: 8];
  end

  wire do_apply = (state_q == S_MFIN) ||
                  (state_q == S_LOOK && !is_mem && sel && !need_wb);
  wire fill_last = (state_q == S_FILL) && mem_rvalid && (rcnt_q == 3'd7);

  assign req_ready = (state_q == S_IDLE);
  assign mem_valid = (state_q == S_WB) || (state_q == S_FILL && !wcnt_q[3]);
  assign mem_write = (state_q == S_WB);
  assign mem_addr  = (state_q == S_WB) ? {tag_q[idx], idx, wcnt_q[2:0], 2'b00}
                                       : {addr_q[31:5], wcnt_q[2:0], 2'b00};
  assign mem_wdata = data_q[{idx, wcnt_q[2:0]}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_INIT;
      sweep_q   <= '0;
      wcnt_q    <= '0;
      rcnt_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      op_q      <= OP_LOAD;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        S_INIT: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == IDX_W'(LINES - 1)) state_q <= S_IDLE;
        end
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          if (is_mem) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= (op_q == OP_LOAD) ? cur_word : 32'd0;
              state_q   <= S_IDLE;
            end else begin
              state_q <= vdirty ? S_WB : S_FILL;
            end
          end else if (sel && need_wb) begin
            state_q <= S_WB;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= 32'd0;
            state_q   <= S_IDLE;
          end
        end
        S_WB: if (mem_ready) begin
          if (wcnt_q == 4'd7) begin
            wcnt_q  <= '0;
            state_q <= is_mem ? S_FILL : S_MFIN;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        S_FILL: begin
          if (mem_valid && mem_ready) wcnt_q <= wcnt_q + 1'b1;
          if (mem_rvalid) rcnt_q <= rcnt_q + 1'b1;
          if (fill_last) begin
            wcnt_q  <= '0;
            state_q <= S_LOOK;
          end
        end
        S_MFIN: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= 32'd0;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_INIT) begin
      valid_q[sweep_q] <= 1'b0;
      dirty_q[sweep_q] <= 1'b0;
    end
    if (state_q == S_LOOK && op_q == OP_STORE && hit) begin
      data_q[{idx, woff}] <= merged;
      dirty_q[idx]        <= 1'b1;
    end
    if (state_q == S_FILL && mem_rvalid) data_q[{idx, rcnt_q}] <= mem_rdata;
    if (fill_last) begin
      tag_q[idx]   <= tagf;
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end
    if (do_apply) begin
      dirty_q[idx] <= 1'b0;
      if (!k_clean) valid_q[idx] <= 1'b0;
    end
  end

  // R6
  wb_dirty_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> valid_q[idx] && dirty_q[idx]);

  // R10
  inval_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> !(op_q == OP_INV_A || op_q == OP_INV_I));

  // R5
  fill_installs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state_q == S_FILL) && state_q == S_LOOK |-> valid_q[idx] && !dirty_q[idx] && tag_q[idx] == tagf);

  // R4
  store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_LOOK && op_q == OP_STORE && hit |=> valid_q[idx] && dirty_q[idx]);

  // R11
  mgmt_miss_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_LOOK && !is_mem && !by_idx && !hit |=> valid_q == $past(valid_q) && dirty_q == $past(dirty_q));

  // R9
  flush_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_MFIN && !k_clean |=> !valid_q[idx] && !dirty_q[idx]);

  // R8
  clean_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_MFIN && k_clean |=> valid_q[idx] && !dirty_q[idx]);
endmodule

// File: tb/dcache_wb_test.sv
module dcache_wb_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_op = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  dcache_wb #(.CACHE_BYTES(1024)) uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_wdata, .req_be,
    .rsp_valid, .rsp_rdata, .mem_valid, .mem_write, .mem_addr, .mem_wdata,
    .mem_ready, .mem_rvalid, .mem_rdata);

  logic [31:0] mem [4096];
  int rd_total = 0, wr_total = 0, ord_err = 0, cyc = 0;
  logic [31:0] last_rd = 32'h1C, last_wr = 32'h1C;
  int checks = 0, fails = 0;

  assign mem_ready = (cyc % 4) != 3;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        if ((wr_total % 8 == 0) ? (mem_addr[4:0] != 0) : (mem_addr != last_wr + 4)) ord_err <= ord_err + 1;
        last_wr <= mem_addr;
        wr_total <= wr_total + 1;
        mem[mem_addr[13:2]] <= mem_wdata;
      end else begin
        if ((wr_total % 8 != 0) ||
            ((rd_total % 8 == 0) ? (mem_addr[4:0] != 0) : (mem_addr != last_rd + 4))) ord_err <= ord_err + 1;
        last_rd <= mem_addr;
        rd_total <= rd_total + 1;
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr[13:2]];
      end
    end
  end

  typedef struct packed {
    bit [23:0] tag; bit [2:0] op; bit [31:0] addr; bit [31:0] wd; bit [3:0] be;
    bit [31:0] exp; bit [3:0] nr; bit [3:0] nw;
  } vec_t;

  localparam vec_t VT [34] = '{
    '{"R5 ", 3'd0, 32'h104, 32'h0,        4'h0, 32'hA0000041, 4'd8, 4'd0},
    '{"R3 ", 3'd0, 32'h108, 32'h0,        4'h0, 32'hA0000042, 4'd0, 4'd0},
    '{"R4 ", 3'd1, 32'h104, 32'h11223344, 4'h3, 32'h0,        4'd0, 4'd0},
    '{"R3 ", 3'd0, 32'h104, 32'h0,        4'h0, 32'hA0003344, 4'd0, 4'd0},
    '{"R6 ", 3'd0, 32'h504, 32'h0,        4'h0, 32'hA0000141, 4'd8, 4'd8},
    '{"R6 ", 3'd0, 32'h104, 32'h0,        4'h0, 32'hA0003344, 4'd8, 4'd0},
    '{"R7 ", 3'd1, 32'h904, 32'hDEADBEEF, 4'hF, 32'h0,        4'd8, 4'd0},
    '{"R8 ", 3'd2, 32'h900, 32'h0,        4'h0, 32'h0,        4'd0, 4'd8},
    '{"R8 ", 3'd0, 32'h904, 32'h0,        4'h0, 32'hDEADBEEF, 4'd0, 4'd0},
    '{"R8 ", 3'd0, 32'h104, 32'h0,        4'h0, 32'hA0003344, 4'd8, 4'd0},
    '{"R8 ", 3'd0, 32'h904, 32'h0,        4'h0, 32'hDEADBEEF, 4'd8, 4'd0},
    '{"R4 ", 3'd1, 32'h908, 32'h55AA55AA, 4'hF, 32'h0,        4'd0, 4'd0},
    '{"R11", 3'd3, 32'hD00, 32'h0,        4'h0, 32'h0,        4'd0, 4'd0},
    '{"R11", 3'd0, 32'h908, 32'h0,        4'h0, 32'h55AA55AA, 4'd0, 4'd0},
    '{"R9 ", 3'd3, 32'h900, 32'h0,        4'h0, 32'h0,        4'd0, 4'd8},
    '{"R9 ", 3'd0, 32'h908, 32'h0,        4'h0, 32'h55AA55AA, 4'd8, 4'd0},
    '{"R4 ", 3'd1, 32'h908, 32'h12345678, 4'hF, 32'h0,        4'd0, 4'd0},
    '{"R10", 3'd4, 32'h900, 32'h0,        4'h0, 32'h0,        4'd0, 4'd0},
    '{"R10", 3'd0, 32'h908, 32'h0,        4'h0, 32'h55AA55AA, 4'd8, 4'd0},
    '{"R11", 3'd4, 32'h100, 32'h0,        4'h0, 32'h0,        4'd0, 4'd0},
    '{"R11", 3'd0, 32'h90C, 32'h0,        4'h0, 32'hA0000243, 4'd0, 4'd0},
    '{"R7 ", 3'd1, 32'h064, 32'hCAFEF00D, 4'hF, 32'h0,        4'd8, 4'd0},
    '{"R1 ", 3'd5, 32'h003, 32'h0,        4'h0, 32'h0,        4'd0, 4'd8},
    '{"R12", 3'd0, 32'h464, 32'h0,        4'h0, 32'hA0000119, 4'd8, 4'd0},
    '{"R12", 3'd0, 32'h064, 32'h0,        4'h0, 32'hCAFEF00D, 4'd8, 4'd0},
    '{"R4 ", 3'd1, 32'h068, 32'h0BADC0DE, 4'hC, 32'h0,        4'd0, 4'd0},
    '{"R12", 3'd6, 32'h003, 32'h0,        4'h0, 32'h0,        4'd0, 4'd8},
    '{"R12", 3'd0, 32'h068, 32'h0,        4'h0, 32'h0BAD001A, 4'd8, 4'd0},
    '{"R4 ", 3'd1, 32'h068, 32'hFFFFFFFF, 4'h1, 32'h0,        4'd0, 4'd0},
    '{"R12", 3'd7, 32'h003, 32'h0,        4'h0, 32'h0,        4'd0, 4'd0},
    '{"R12", 3'd0, 32'h068, 32'h0,        4'h0, 32'h0BAD001A, 4'd8, 4'd0},
    '{"R12", 3'd6, 32'h005, 32'h0,        4'h0, 32'h0,        4'd0, 4'd0},
    '{"R12", 3'd5, 32'h003, 32'h0,        4'h0, 32'h0,        4'd0, 4'd0},
    '{"R12", 3'd0, 32'h064, 32'h0,        4'h0, 32'hCAFEF00D, 4'd0, 4'd0}
  };

  task automatic check(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    int r0, w0, e0, lat;
    string t;
    t = $sformatf("%s", v.tag);
    while (!req_ready) @(negedge clk);
    r0 = rd_total; w0 = wr_total; e0 = ord_err;
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_wdata = v.wd; req_be = v.be;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 500) begin @(negedge clk); lat++; end
    check(rsp_valid && rsp_rdata == v.exp, t, "response data", rsp_rdata, v.exp);
    check(rd_total - r0 == int'(v.nr), t, "read count", 32'(rd_total - r0), 32'(v.nr));
    check(wr_total - w0 == int'(v.nw), t, "write count", 32'(wr_total - w0), 32'(v.nw));
    if (v.nr != 0 || v.nw != 0)
      check(ord_err == e0, t, "access order", 32'(ord_err - e0), 32'd0);
    if (v.nr != 0)
      check(last_rd[31:5] == v.addr[31:5], t, "refill line", last_rd, {v.addr[31:5], 5'h1C});
    if (v.nr == 0 && v.nw == 0)
      check(lat == 1, t, "latency", 32'(lat), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < 4096; i++) mem[i] = 32'hA000_0000 + i;
    mem_rvalid = 1'b0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R2: held in reset, not ready
    check(req_ready == 1'b0, "R2", "ready in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    cnt = 0;
    while (!req_ready && cnt < 1000) begin
      @(negedge clk);
      cnt++;
      if (mem_valid) check(1'b0, "R2", "traffic during sweep", 32'd1, 32'd0);
    end
    // R2: sweep length is one cycle per line
    check(cnt == 32, "R2", "sweep cycles", 32'(cnt), 32'd32);
    for (int i = 0; i < 34; i++) run(VT[i]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule